// File: doc/BRIEF.md
# Sampling Clock Slow Detector

This block watches an asynchronous sampling clock from the bus-clock domain and reports when that clock has become too slow. The sampling clock toggles a single flop in its own domain. The toggle signal passes through a two-stage synchronizer into the bus domain. A bus-domain counter then measures how many bus cycles go by between successive toggle edges. The design rule is that the undivided sampling clock must run faster than the bus clock divided by 32. Because the synchronizer adds jitter, the block declares an error only when more than 32 plus a margin of 4 bus cycles pass without a toggle edge.

Two flags come out of the block. The live status follows the condition and clears by itself once edges arrive inside the limit again. The sticky flag is set together with the live status and is cleared only when software writes a 0 to it. An interrupt request is raised while the sticky flag is set and interrupts are enabled. The detection-disable setting is captured only while the generator is off, so it cannot change during operation. A clock error only raises flags; nothing in this block holds back the data path.

Top module: `sclk_watchdog`

## Requirements
- R1: With the sampling clock period at or below 30 bus cycles, neither clkErrLive nor clkErrSticky is ever set.
- R2: With the sampling period above 40 bus cycles, or with the sampling clock stopped, clkErrLive is 1 within 40 bus cycles of the last toggle edge and stays 1 while the condition lasts.
- R3: clkErrSticky is set in the same cycle that clkErrLive rises.
- R4: After the sampling clock returns to a period at or below 30 bus cycles, clkErrLive returns to 0 by itself, and clkErrSticky stays 1.
- R5: A clear write (swClrWrite = 1) with swClrData = 0 clears clkErrSticky on the next bus edge. A write with swClrData = 1 has no effect. While the error condition persists, the flag is set again at once.
- R6: While detection is disabled (latched detectDisable = 1), clkErrLive reads 0 and clkErrSticky is not set, even with a stopped sampling clock.
- R7: detectDisable is sampled only while genEnable = 0. A change while genEnable = 1 has no effect until the generator is disabled again.
- R8: irqPending is 1 exactly when clkErrSticky = 1 and irqEnable = 1.
- R9: With genEnable = 0, clkErrLive reads 0 within one bus cycle, and clkErrSticky keeps its value.
- R10: After reset, clkErrLive, clkErrSticky and irqPending are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock; all flags and the counter run on it |
| busRstN | input | 1 | Active-low asynchronous reset for both domains |
| smpClk | input | 1 | Undivided sampling clock being supervised |
| detectDisable | input | 1 | 1 disables detection; captured while genEnable = 0 |
| genEnable | input | 1 | Generator enable; detection runs only while high |
| irqEnable | input | 1 | Interrupt enable for the sticky flag |
| swClrWrite | input | 1 | One-cycle software write strobe to the sticky flag |
| swClrData | input | 1 | Value written; 0 clears, 1 leaves the flag alone |
| clkErrLive | output | 1 | Live clock-error status |
| clkErrSticky | output | 1 | Sticky clock-error flag |
| irqPending | output | 1 | Interrupt request |

## Verification
The bench drives sampling periods picked at random from clearly fast and clearly slow bands, plus a stopped clock. A counter limit off by a wide margin would fail these cases, and so would a live flag that never clears. Sticky-flag clearing is tried with a write of 1, with a write of 0 after recovery, and with a write of 0 while the clock is still stopped. A design that cleared on any write, or let the clear beat a live error, would leave the flag in the wrong state. A detection-disable change made while the generator is on, followed by a stopped clock, catches a design that does not hold the setting during operation.

// File: rtl/sclk_wd_pkg.sv
package sclk_wd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } wdStrobe_t;
endpackage

// File: rtl/sclk_wd_dp.sv
module sclk_wd_dp
  import sclk_wd_pkg::*;
#(
  parameter int RATIO       = 32,
  parameter int MARGIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      busClk,
  input  logic      busRstN,
  input  logic      smpClk,
  input  wdStrobe_t stb,
  output logic      edgeSeen,
  output logic      overLimit
);
  localparam int LIMIT = RATIO + MARGIN;
  localparam int CNT_W = $clog2(LIMIT + 2);

  logic smpToggle;
  logic [SYNC_STAGES:0] syncChain;
  logic [CNT_W-1:0] gapCnt;

  // sampling-domain toggle flop
  always_ff @(posedge smpClk or negedge busRstN) begin
    if (!busRstN) smpToggle <= 1'b0;
    else          smpToggle <= ~smpToggle;
  end

  // synchronizer stages plus one history stage
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) syncChain[0] <= 1'b0;
    else          syncChain[0] <= smpToggle;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge busClk or negedge busRstN) begin
      if (!busRstN) syncChain[i] <= 1'b0;
      else          syncChain[i] <= syncChain[i-1];
    end
  end

  assign edgeSeen  = syncChain[SYNC_STAGES] ^ syncChain[SYNC_STAGES-1];
  assign overLimit = gapCnt > CNT_W'(LIMIT);

  // gap counter, saturating one above the limit
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)                     gapCnt <= '0;
    else if (stb.cntClear)            gapCnt <= '0;
    else if (stb.cntRun && !overLimit) gapCnt <= gapCnt + 1'b1;
  end
endmodule

// File: rtl/sclk_wd_ctl.sv
module sclk_wd_ctl
  import sclk_wd_pkg::*;
(
  input  logic      busClk,
  input  logic      busRstN,
  input  logic      detectDisable,
  input  logic      genEnable,
  input  logic      irqEnable,
  input  logic      swClrWrite,
  input  logic      swClrData,
  input  logic      edgeSeen,
  input  logic      overLimit,
  output wdStrobe_t stb,
  output logic      clkErrLive,
  output logic      clkErrSticky,
  output logic      irqPending
);
  logic cfgDisable;
  logic active;

  // setting captured only while the generator is off
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)        cfgDisable <= 1'b0;
    else if (!genEnable) cfgDisable <= detectDisable;
  end

  assign active = genEnable && !cfgDisable;

  always_comb begin
    stb.cntRun   = active;
    stb.cntClear = !active || edgeSeen;
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)       clkErrLive <= 1'b0;
    else if (!active)   clkErrLive <= 1'b0;
    else if (overLimit) clkErrLive <= 1'b1;
    else if (edgeSeen)  clkErrLive <= 1'b0;
  end

  // a set in the same cycle wins over a software clear
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)                      clkErrSticky <= 1'b0;
    else if (active && overLimit)      clkErrSticky <= 1'b1;
    else if (swClrWrite && !swClrData) clkErrSticky <= 1'b0;
  end

  assign irqPending = clkErrSticky && irqEnable;
endmodule

// File: rtl/sclk_watchdog.sv
module sclk_watchdog
  import sclk_wd_pkg::*;
#(
  parameter int RATIO       = 32,
  parameter int MARGIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic busClk,
  input  logic busRstN,
  input  logic smpClk,
  input  logic detectDisable,
  input  logic genEnable,
  input  logic irqEnable,
  input  logic swClrWrite,
  input  logic swClrData,
  output logic clkErrLive,
  output logic clkErrSticky,
  output logic irqPending
);
  wdStrobe_t stb;
  logic edgeSeen;
  logic overLimit;

  sclk_wd_dp #(.RATIO(RATIO), .MARGIN(MARGIN), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .busClk(busClk), .busRstN(busRstN), .smpClk(smpClk), .stb(stb),
    .edgeSeen(edgeSeen), .overLimit(overLimit)
  );

  sclk_wd_ctl i_ctl (
    .busClk(busClk), .busRstN(busRstN), .detectDisable(detectDisable),
    .genEnable(genEnable), .irqEnable(irqEnable), .swClrWrite(swClrWrite),
    .swClrData(swClrData), .edgeSeen(edgeSeen), .overLimit(overLimit),
    .stb(stb), .clkErrLive(clkErrLive), .clkErrSticky(clkErrSticky),
    .irqPending(irqPending)
  );
endmodule

module sclk_watchdog_chk
  import sclk_wd_pkg::*;
(
  input logic      busClk,
  input logic      busRstN,
  input logic      genEnable,
  input logic      irqEnable,
  input logic      swClrWrite,
  input logic      swClrData,
  input logic      clkErrLive,
  input logic      clkErrSticky,
  input logic      irqPending,
  input wdStrobe_t stb,
  input logic      edgeSeen,
  input logic      overLimit
);
  logic seen;
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) seen <= 1'b0;
    else          seen <= 1'b1;
  end

  a_r9_off_live_low: assert property (@(posedge busClk) disable iff (!busRstN)
    !genEnable |=> !clkErrLive);
  a_r3_set_together: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(clkErrLive) |-> clkErrSticky);
  a_r3_sticky_with_live: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(clkErrSticky) |-> clkErrLive);
  a_r5_sticky_holds: assert property (@(posedge busClk) disable iff (!busRstN)
    clkErrSticky && !(swClrWrite && !swClrData) |=> clkErrSticky);
  a_r4_live_clears: assert property (@(posedge busClk) disable iff (!busRstN)
    clkErrLive && stb.cntRun && edgeSeen && !overLimit |=> !clkErrLive);
  a_r2_live_needs_gap: assert property (@(posedge busClk) disable iff (!busRstN)
    seen && $rose(clkErrLive) |-> $past(overLimit));
  a_r7_cfg_hold: assert property (@(posedge busClk) disable iff (!busRstN)
    seen && genEnable && $past(genEnable) |-> $stable(stb.cntRun));
  a_r8_irq_needs_enable: assert property (@(posedge busClk) disable iff (!busRstN)
    irqPending |-> clkErrSticky && irqEnable);
endmodule

bind sclk_watchdog sclk_watchdog_chk i_chk (.*);

// File: tb/test_sclk_watchdog.sv
`timescale 1ns/1ps
module test_sclk_watchdog;
  logic busClk = 1'b0;
  logic smpClk = 1'b0;
  logic busRstN = 1'b0;
  logic detectDisable = 1'b0, genEnable = 1'b0, irqEnable = 1'b0;
  logic swClrWrite = 1'b0, swClrData = 1'b1;
  logic clkErrLive, clkErrSticky, irqPending;

  int smpHalf = 50;   // ns
  bit smpRun = 1'b1;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  sclk_watchdog i_sclk_watchdog (.*);

  always #10 busClk = ~busClk;   // 50 MHz

  always begin
    if (smpRun) begin
      #(smpHalf);
      smpClk = ~smpClk;
    end else #10;
  end

  // slow when the period exceeds the limit of 36 bus cycles
  function automatic logic expSlow(int periodCycles);
    return periodCycles > 36;
  endfunction

  function automatic logic expIrq(logic sticky, logic ie);
    return sticky && ie;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge busClk);
  endtask

  task automatic setPeriod(int cycles);
    smpHalf = cycles * 10;
    smpRun = 1'b1;
  endtask

  task automatic clrWrite(logic d);
    @(negedge busClk);
    swClrWrite = 1'b1; swClrData = d;
    @(negedge busClk);
    swClrWrite = 1'b0; swClrData = 1'b1;
    @(negedge busClk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    waitCyc(3);
    busRstN = 1'b1;
    waitCyc(2);
    // R10 reset state
    chk("R10 live", clkErrLive, 1'b0);
    chk("R10 sticky", clkErrSticky, 1'b0);
    chk("R10 irq", irqPending, 1'b0);

    genEnable = 1'b1;
    setPeriod(5);
    waitCyc(200);
    chk("R1 fast live", clkErrLive, 1'b0);
    chk("R1 fast sticky", clkErrSticky, 1'b0);

    // random fast/slow bands
    for (int it = 0; it < 12; it++) begin
      int cyc;
      logic slow;
      slow = 1'($urandom % 2);
      cyc = slow ? 45 + int'($urandom % 40) : 3 + int'($urandom % 28);
      irqEnable = 1'($urandom % 2);
      setPeriod(cyc);
      waitCyc(300);
      chk(slow ? "R2 slow live" : "R1 fast live", clkErrLive, expSlow(cyc));
      chk("R3 sticky with live", clkErrSticky, expSlow(cyc));
      chk("R8 irq", irqPending, expIrq(expSlow(cyc), irqEnable));
      setPeriod(5);
      waitCyc(100);
      chk("R4 live self-clear", clkErrLive, 1'b0);
      chk("R4 sticky kept", clkErrSticky, expSlow(cyc));
      clrWrite(1'b1);
      chk("R5 write one ignored", clkErrSticky, expSlow(cyc));
      clrWrite(1'b0);
      chk("R5 write zero clears", clkErrSticky, 1'b0);
      chk("R8 irq after clear", irqPending, 1'b0);
    end

    // boundary bands near the threshold
    irqEnable = 1'b1;
    setPeriod(30);
    waitCyc(400);
    chk("R1 period 30 live", clkErrLive, 1'b0);
    chk("R1 period 30 sticky", clkErrSticky, 1'b0);
    setPeriod(42);
    waitCyc(400);
    chk("R2 period 42 live", clkErrLive, 1'b1);
    chk("R8 irq set", irqPending, 1'b1);
    setPeriod(5);
    waitCyc(100);
    clrWrite(1'b0);

    // stopped clock: error persists, clear cannot hold
    smpRun = 1'b0;
    waitCyc(60);
    chk("R2 stopped live", clkErrLive, 1'b1);
    clrWrite(1'b0);
    chk("R5 re-set while persisting", clkErrSticky, 1'b1);

    // R9 generator off: live low, sticky kept
    @(negedge busClk); genEnable = 1'b0;
    waitCyc(2);
    chk("R9 off live", clkErrLive, 1'b0);
    chk("R9 off sticky kept", clkErrSticky, 1'b1);
    clrWrite(1'b0);
    chk("R9 clear while off", clkErrSticky, 1'b0);

    // R6 detection disabled, stopped clock
    detectDisable = 1'b1;
    waitCyc(2);
    genEnable = 1'b1;
    waitCyc(100);
    chk("R6 disabled live", clkErrLive, 1'b0);
    chk("R6 disabled sticky", clkErrSticky, 1'b0);

    // R7 change while enabled is ignored
    detectDisable = 1'b0;
    waitCyc(100);
    chk("R7 change ignored live", clkErrLive, 1'b0);
    genEnable = 1'b0;
    waitCyc(2);
    genEnable = 1'b1;
    waitCyc(100);
    chk("R7 takes effect after off", clkErrLive, 1'b1);
    genEnable = 1'b0;
    detectDisable = 1'b0;
    setPeriod(5);
    waitCyc(2);
    genEnable = 1'b1;
    detectDisable = 1'b1;   // while enabled: must be ignored
    waitCyc(20);
    smpRun = 1'b0;
    waitCyc(100);
    chk("R7 enable-time set ignored", clkErrLive, 1'b1);

    done = 1'b1;
    report();
  end
endmodule